// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache

This block is a two-way set-associative data cache with a write-back policy. It picks the set from address bits that lie inside the page offset. Those bits are the same in the virtual and the physical address, so the tag and data arrays are read while the translation unit is still working on the page number. One cycle after a request is accepted, both ways of the selected set are on hand. The physical page number from the translation unit is then compared with the tag of each way. The stored tags are physical page numbers, so two virtual pages that map to one physical page share the cached line. A process switch needs no flush.

A request carries a virtual address, a read/write flag and a write word. The translated page number arrives on its own input with a valid strobe. While that strobe stays low, the lookup waits. On a miss, the line that is not most recently used is replaced. If that line is dirty, it is first written out at the address built from its stored page number and the set index. The new line is then fetched, and the request is replayed against the arrays. Each memory transfer moves a whole line.

With the default parameters, lines are 16 bytes and pages are 4 KB. The set index is therefore vaddr[11:4], giving 256 sets. The word select is vaddr[3:2], and memory addresses are 28-bit physical byte addresses.

Top module: `vipt_cache`

## Requirements
- R1: After reset no line is valid, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and the first access to any address misses and issues a memory read.
- R2: The set is chosen by vaddr[11:4] and the word by vaddr[3:2]. Virtual address bits 31:12 never affect the result, so any two virtual addresses that share bits 11:0 and the same page number reach the same data.
- R3: A request hits when the supplied page number equals the stored tag of a valid way in the selected set. A read hit returns the addressed word with no memory transfer, and at most one way hits.
- R4: While `ppn_valid` is low in the lookup cycle, the request stalls and `resp_valid` stays 0. The request completes after `ppn_valid` rises.
- R5: A read miss issues a line read at physical address {ppn, index, 4'b0000}. It returns the word of the fetched line, and `mem_addr` stays stable while `mem_req` waits for `mem_ack`.
- R6: A write hit replaces the addressed word in the cache and marks the line dirty, with no memory write at that time.
- R7: Each set keeps one most-recently-used mark, set to the hit way on a hit and to the filled way on a fill. The replacement victim is always the other way.
- R8: A miss whose victim is valid and dirty first writes that line to {victim tag, index, 4'b0000}, and the fill read follows. A later miss to the evicted address returns the data that was written.
- R9: A miss whose victim is clean or invalid issues no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle, request accepted on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | VA_W | Virtual byte address |
| req_wdata | input | WORD_W | Write word |
| ppn_valid | input | 1 | Translated page number valid |
| ppn | input | PA_W-PAGE_BITS | Physical page number from translation |
| resp_valid | output | 1 | Request complete (one cycle) |
| resp_rdata | output | WORD_W | Read word |
| mem_req | output | 1 | Memory line transfer requested |
| mem_we | output | 1 | 1 = line write-back, 0 = line fill |
| mem_addr | output | PA_W | Physical line byte address |
| mem_wdata | output | LINE_BYTES*8 | Victim line for write-back |
| mem_ack | input | 1 | Transfer done; fill data valid |
| mem_rdata | input | LINE_BYTES*8 | Fill line |

## Verification
A single miss can trigger two actions: the eviction of a dirty line and the fill of the new one. Both must happen, in the right order and at different page addresses. The bench causes this by dirtying a line, forcing that line to become the non-MRU way, and then missing on a third page number at the same index. It judges the result by the write-back address (the old page number), the ordering of the logged memory write before the read, and a later read of the evicted word that must come back from memory. A stalled translation that falls on a write hit is also covered: the bench watches `resp_valid` during each stalled cycle, and a read afterwards must return the written word.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FILL,
    ST_REPLAY
  } vc_state_e;
endpackage

// File: rtl/vipt_way.sv
module vipt_way #(
  parameter int SETS   = 256,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic              wr_tag_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [TAG_W-1:0]  wr_tag,
  output logic [LINE_W-1:0] rd_line,
  output logic [TAG_W-1:0]  rd_tag
);
  logic [LINE_W-1:0] line_mem [SETS];
  logic [TAG_W-1:0]  tag_mem  [SETS];

  // Registered read port; output holds while rd_en is low.
  always_ff @(posedge clk) begin
    if (wr_en)     line_mem[wr_idx] <= wr_line;
    if (wr_tag_en) tag_mem[wr_idx]  <= wr_tag;
    if (rd_en) begin
      rd_line <= line_mem[rd_idx];
      rd_tag  <= tag_mem[rd_idx];
    end
  end
endmodule

// File: rtl/vipt_setstate.sv
module vipt_setstate #(
  parameter int SETS  = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic             hit_en,
  input  logic             hit_way,
  input  logic             hit_dirty,
  output logic [1:0]       valid_o,
  output logic [1:0]       dirty_o,
  output logic             mru_o
);
  logic [1:0]      valid_q [SETS];
  logic [1:0]      dirty_q [SETS];
  logic [SETS-1:0] mru_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
      mru_q <= '0;
    end else if (fill_en) begin
      valid_q[idx][fill_way] <= 1'b1;
      dirty_q[idx][fill_way] <= 1'b0;
      mru_q[idx]             <= fill_way;
    end else if (hit_en) begin
      if (hit_dirty) dirty_q[idx][hit_way] <= 1'b1;
      mru_q[idx] <= hit_way;
    end
  end

  assign valid_o = valid_q[idx];
  assign dirty_o = dirty_q[idx];
  assign mru_o   = mru_q[idx];

  // R7: a fill leaves the filled way as most recently used
  a_r7_fill_sets_mru: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (mru_q[$past(idx)] == $past(fill_way)));
  // R7: a hit leaves the hit way as most recently used
  a_r7_hit_sets_mru: assert property (@(posedge clk) disable iff (rst)
    (hit_en && !fill_en) |=> (mru_q[$past(idx)] == $past(hit_way)));
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 28,
  parameter int PAGE_BITS  = 12,
  parameter int LINE_BYTES = 16,
  parameter int WORD_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [VA_W-1:0]           req_vaddr,
  input  logic [WORD_W-1:0]         req_wdata,
  input  logic                      ppn_valid,
  input  logic [PA_W-PAGE_BITS-1:0] ppn,
  output logic                      resp_valid,
  output logic [WORD_W-1:0]         resp_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [PA_W-1:0]           mem_addr,
  output logic [LINE_BYTES*8-1:0]   mem_wdata,
  input  logic                      mem_ack,
  input  logic [LINE_BYTES*8-1:0]   mem_rdata
);
  localparam int WAYS   = 2;
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = PAGE_BITS - OFF_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int BW     = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - BW;
  localparam int PPN_W  = PA_W - PAGE_BITS;

  vc_state_e          st;
  logic [IDX_W-1:0]   idx_q;
  logic [WSEL_W-1:0]  wsel_q;
  logic               we_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [PPN_W-1:0]   ppn_q;
  logic               ppn_held;
  logic               vict_q;

  logic [LINE_W-1:0]  way_line [WAYS];
  logic [PPN_W-1:0]   way_tag  [WAYS];
  logic [1:0]         valid_s, dirty_s;
  logic               mru_s;

  logic               ppn_ok;
  logic [PPN_W-1:0]   ppn_use;
  logic [WAYS-1:0]    hit_w;
  logic               hit, hit_way, victim, look_hit, fill_done;
  logic [LINE_W-1:0]  merged;
  logic               rd_en;
  logic [IDX_W-1:0]   rd_idx;

  // Translation may arrive late; a captured page number is reused on replay.
  assign ppn_ok  = ppn_held | ppn_valid;
  assign ppn_use = ppn_held ? ppn_q : ppn;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_w[w] = valid_s[w] && (way_tag[w] == ppn_use);
  end

  assign hit       = |hit_w;
  assign hit_way   = hit_w[1];
  assign victim    = ~mru_s;
  assign look_hit  = (st == ST_LOOK) && ppn_ok && hit;
  assign fill_done = (st == ST_FILL) && mem_ack;

  always_comb begin
    merged = way_line[hit_way];
    merged[wsel_q*WORD_W +: WORD_W] = wdata_q;
  end

  // Arrays are indexed from page-offset bits straight off the request.
  assign rd_en  = ((st == ST_IDLE) && req_valid) || (st == ST_REPLAY);
  assign rd_idx = (st == ST_IDLE) ? req_vaddr[OFF_W +: IDX_W] : idx_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_line_en;
    assign wr_line_en = (look_hit && we_q && (hit_way == w[0])) ||
                        (fill_done && (vict_q == w[0]));
    vipt_way #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(PPN_W), .LINE_W(LINE_W)) u_way (
      .clk       (clk),
      .rd_en     (rd_en),
      .rd_idx    (rd_idx),
      .wr_en     (wr_line_en),
      .wr_tag_en (fill_done && (vict_q == w[0])),
      .wr_idx    (idx_q),
      .wr_line   (fill_done ? mem_rdata : merged),
      .wr_tag    (ppn_q),
      .rd_line   (way_line[w]),
      .rd_tag    (way_tag[w])
    );
  end

  vipt_setstate #(.SETS(SETS), .IDX_W(IDX_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .idx       (idx_q),
    .fill_en   (fill_done),
    .fill_way  (vict_q),
    .hit_en    (look_hit),
    .hit_way   (hit_way),
    .hit_dirty (we_q),
    .valid_o   (valid_s),
    .dirty_o   (dirty_s),
    .mru_o     (mru_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      ppn_held   <= 1'b0;
      ppn_q      <= '0;
      vict_q     <= 1'b0;
      idx_q      <= '0;
      wsel_q     <= '0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          idx_q    <= req_vaddr[OFF_W +: IDX_W];
          wsel_q   <= req_vaddr[BW +: WSEL_W];
          we_q     <= req_we;
          wdata_q  <= req_wdata;
          ppn_held <= 1'b0;
          st       <= ST_LOOK;
        end
        ST_LOOK: if (ppn_ok) begin
          if (hit) begin
            resp_valid <= 1'b1;
            resp_rdata <= way_line[hit_way][wsel_q*WORD_W +: WORD_W];
            st         <= ST_IDLE;
          end else begin
            ppn_q    <= ppn_use;
            ppn_held <= 1'b1;
            vict_q   <= victim;
            mem_req  <= 1'b1;
            if (valid_s[victim] && dirty_s[victim]) begin
              mem_we   <= 1'b1;
              mem_addr <= {way_tag[victim], idx_q, {OFF_W{1'b0}}};
              st       <= ST_WB;
            end else begin
              mem_we   <= 1'b0;
              mem_addr <= {ppn_use, idx_q, {OFF_W{1'b0}}};
              st       <= ST_FILL;
            end
          end
        end
        ST_WB: if (mem_ack) begin
          mem_we   <= 1'b0;
          mem_addr <= {ppn_q, idx_q, {OFF_W{1'b0}}};
          st       <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          mem_req <= 1'b0;
          st      <= ST_REPLAY;
        end
        ST_REPLAY: st <= ST_LOOK;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign mem_wdata = way_line[vict_q];

  // R4: no completion while the page number is missing
  a_r4_stall_no_resp: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK && !ppn_ok) |=> (!resp_valid && st == ST_LOOK));
  // R3: two ways of a set never hold the same page number
  a_r3_single_hit: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOK) |-> $onehot0(hit_w));
  // R8: a finished write-back is followed directly by the fill read
  a_r8_wb_then_fill: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));
  // R5: the transfer address holds until acknowledged
  a_r5_mem_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R6: a write hit leaves its way dirty
  a_r6_write_marks_dirty: assert property (@(posedge clk) disable iff (rst)
    (look_hit && we_q) |=> dirty_s[$past(hit_way)]);
endmodule

// File: tb/vipt_cache_test.sv
module vipt_cache_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_we = 1'b0;
  logic [31:0]  req_vaddr = '0;
  logic [31:0]  req_wdata = '0;
  logic         ppn_valid = 1'b0;
  logic [15:0]  ppn = '0;
  logic         resp_valid;
  logic [31:0]  resp_rdata;
  logic         mem_req, mem_we;
  logic [27:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #5 clk = ~clk;

  vipt_cache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
    .ppn_valid(ppn_valid), .ppn(ppn), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input logic [27:0] pa);
    return {4'h0, pa[27:2], 2'b00} ^ 32'h5A00_C300;
  endfunction

  // Memory model: line-wide, two cycles of latency, logs transfer order.
  logic [127:0] mem_line [int];
  int lat = 0, seq = 0, rd_cnt = 0, wr_cnt = 0, last_rd_seq = 0, last_wr_seq = 0;
  logic [27:0] last_rd_addr = '0, last_wr_addr = '0;

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      lat = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat == 2) begin
        lat = 0;
        mem_ack <= 1'b1;
        seq++;
        if (mem_we) begin
          mem_line[int'(mem_addr >> 4)] = mem_wdata;
          wr_cnt++; last_wr_addr = mem_addr; last_wr_seq = seq;
        end else begin
          logic [127:0] l;
          if (mem_line.exists(int'(mem_addr >> 4))) l = mem_line[int'(mem_addr >> 4)];
          else for (int i = 0; i < 4; i++) l[i*32 +: 32] = pat(mem_addr + 28'(4*i));
          mem_rdata <= l;
          rd_cnt++; last_rd_addr = mem_addr; last_rd_seq = seq;
        end
      end else lat++;
    end
  end

  // Architectural reference and scoreboard.
  logic [31:0] ref_mem [int];
  typedef struct { logic we; logic [31:0] d; string t; } exp_t;
  exp_t exp_q [$];

  always @(negedge clk) begin
    if (!rst && resp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected response", 64'(resp_rdata), 64'h0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        if (!e.we) chk(resp_rdata == e.d, e.t, "read data", 64'(resp_rdata), 64'(e.d));
      end
    end
  end

  task automatic access(input logic [31:0] va, input logic [15:0] p, input logic we,
                        input logic [31:0] wd, input int dly, input string tag);
    logic [27:0] pa;
    exp_t e;
    int k;
    pa = {p, va[11:0]};
    k = int'(pa >> 2);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    e.we = we; e.t = tag;
    e.d = ref_mem.exists(k) ? ref_mem[k] : pat(pa);
    exp_q.push_back(e);
    if (we) ref_mem[k] = wd;
    req_valid = 1'b1; req_we = we; req_vaddr = va; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < dly; i++) begin
      chk(resp_valid == 1'b0, "R4", "response during stall", 64'(resp_valid), 64'h0);
      @(negedge clk);
    end
    ppn_valid = 1'b1; ppn = p;
    while (!resp_valid) @(negedge clk);
    ppn_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'h1);
    chk(resp_valid == 1'b0, "R1", "resp after reset", 64'(resp_valid), 64'h0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'h0);

    access(32'h0000_1040, 16'h5, 1'b0, '0, 0, "R1");
    chk(rd_cnt == 1, "R1", "cold miss reads memory", 64'(rd_cnt), 64'd1);
    chk(last_rd_addr == 28'h0005040, "R5", "fill address", 64'(last_rd_addr), 64'h0005040);

    access(32'h0002_3044, 16'h5, 1'b0, '0, 0, "R2");
    chk(rd_cnt == 1, "R3", "alias hit without traffic", 64'(rd_cnt), 64'd1);

    access(32'h7777_7048, 16'h5, 1'b1, 32'hDEAD_BEEF, 3, "R4");
    chk(rd_cnt == 1 && wr_cnt == 0, "R6", "write hit no traffic", 64'(rd_cnt + wr_cnt), 64'd1);
    access(32'h0000_1048, 16'h5, 1'b0, '0, 0, "R6");

    access(32'h0000_9040, 16'h9, 1'b0, '0, 0, "R5");
    chk(rd_cnt == 2 && wr_cnt == 0, "R9", "invalid victim no write", 64'(wr_cnt), 64'd0);

    access(32'h0000_1040, 16'h5, 1'b0, '0, 1, "R7");
    access(32'h0000_B040, 16'hB, 1'b0, '0, 0, "R7");
    chk(rd_cnt == 3 && wr_cnt == 0, "R9", "clean victim no write", 64'(wr_cnt), 64'd0);
    access(32'h0000_1044, 16'h5, 1'b0, '0, 0, "R7");
    chk(rd_cnt == 3, "R7", "MRU way kept", 64'(rd_cnt), 64'd3);

    access(32'h0000_9040, 16'h9, 1'b0, '0, 0, "R7");
    chk(rd_cnt == 4 && wr_cnt == 0, "R7", "non-MRU clean way replaced", 64'(rd_cnt), 64'd4);

    access(32'h0000_C04C, 16'hC, 1'b0, '0, 2, "R8");
    chk(wr_cnt == 1, "R8", "dirty victim written", 64'(wr_cnt), 64'd1);
    chk(last_wr_addr == 28'h0005040, "R8", "write-back address", 64'(last_wr_addr), 64'h0005040);
    chk(last_rd_addr == 28'h000C040, "R8", "fill after write-back", 64'(last_rd_addr), 64'h000C040);
    chk(last_wr_seq < last_rd_seq, "R8", "write-back before fill", 64'(last_wr_seq), 64'(last_rd_seq));

    access(32'h0000_1048, 16'h5, 1'b0, '0, 0, "R8");
    chk(wr_cnt == 1, "R9", "clean eviction no write", 64'(wr_cnt), 64'd1);

    access(32'h0000_53F8, 16'h21, 1'b1, 32'h1234_5678, 0, "R2");
    access(32'h0000_13F8, 16'h21, 1'b0, '0, 0, "R2");
    access(32'h0000_13F0, 16'h21, 1'b0, '0, 0, "R2");
    chk(rd_cnt == 7, "R2", "other set one fill only", 64'(rd_cnt), 64'd7);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "all responses seen", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule